// File: doc/BRIEF.md
# Sixteen-Bit Timer with Clear-on-Match and Event Timestamp

This block is a 16-bit up-counter that advances once for each clock cycle in which an external tick enable is high. In free-running mode it wraps from 0xFFFF to 0x0000. In clear-on-match mode it also returns to zero when its value equals a 16-bit TOP value. The TOP value is written one byte at a time through two 8-bit registers, and each write takes effect at once, with no staging.

A timestamp unit watches one of two asynchronous event inputs. It synchronizes the chosen input, and on its rising edge it latches the current count into a capture register. Three sticky flags report a TOP match, a wrap and a capture. Software clears each flag with a dedicated one-cycle pulse. Software reaches the counter, TOP, control and capture registers through a byte-wide write port and a combinational read port.

Top module: `capture_ctc_timer`

## Requirements
- R1: After reset the block is in free-running mode with event input A selected, and the counter, TOP, capture register and all three flags read zero.
- R2: The counter rises by one on each clock edge where `tick_en` is high and holds its value otherwise. In free-running mode TOP has no effect and the match flag is never set.
- R3: The register addresses are: 0 control (bit 0 is the mode, where 1 means clear-on-match; bit 1 is the event source, where 1 means input B), 1 counter bits 7:0, 2 counter bits 15:8, 3 TOP bits 7:0, 4 TOP bits 15:8, 5 capture bits 7:0 and 6 capture bits 15:8. Any other address reads zero. `rd_data` follows `rd_addr` in the same cycle.
- R4: In clear-on-match mode, a tick taken while the counter equals TOP loads zero into the counter and sets `cmp_flag`.
- R5: A TOP write takes effect on the next comparison. If TOP lies below the count, the counter runs up through 0xFFFF and wraps before any match occurs.
- R6: A tick taken at 0xFFFF sets `ovf_flag` in the same edge that the counter becomes 0x0000. This holds in both modes, including a clear-on-match with TOP = 0xFFFF.
- R7: A write to a counter byte replaces that byte. In the same cycle it overrides a tick, and the overridden tick sets no flag.
- R8: The selected event input passes through two flip-flops. A rising edge on the synchronized level copies the counter value into the capture register and sets `cap_flag`. The unselected input has no effect.
- R9: Each flag stays set until its clear pulse is high on a clock edge. If a set and a clear fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable pulse from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| evt_a | input | 1 | Asynchronous event input A |
| evt_b | input | 1 | Asynchronous event input B |
| cmp_clr | input | 1 | Clear pulse for the match flag |
| ovf_clr | input | 1 | Clear pulse for the wrap flag |
| cap_clr | input | 1 | Clear pulse for the capture flag |
| cmp_flag | output | 1 | TOP match seen |
| ovf_flag | output | 1 | Wrap from 0xFFFF seen |
| cap_flag | output | 1 | Timestamp taken |

## Verification
The bench loads the counter above TOP and checks that the counter keeps counting upward rather than clearing. A design that buffered TOP or compared with greater-or-equal would clear too early. It runs the counter through 0xFFFF in both modes, including TOP = 0xFFFF, where a design that treated the match and the wrap as exclusive would drop the wrap flag. It collides a counter write with a tick that would otherwise match, and a flag clear with a flag set; a wrong priority shows up as a stepped count, a spurious match flag or a lost flag. It also raises the unselected event input, which must leave the capture value and `cap_flag` untouched.

// File: rtl/ctc_timer_pkg.sv
package ctc_timer_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL   = 3'd0,
    REG_CNT_LO = 3'd1,
    REG_CNT_HI = 3'd2,
    REG_TOP_LO = 3'd3,
    REG_TOP_HI = 3'd4,
    REG_CAP_LO = 3'd5,
    REG_CAP_HI = 3'd6
  } reg_addr_e;

  localparam int FLAG_CMP  = 0;
  localparam int FLAG_OVF  = 1;
  localparam int FLAG_CAP  = 2;
  localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/ctc_count_core.sv
module ctc_count_core #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               ctc_mode,
  input  logic [CNT_W-1:0]   top_val,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [CNT_W/2-1:0] wr_byte,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               match_evt,
  output logic               wrap_evt
);
  localparam int HALF = CNT_W / 2;
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  // Exact equality only: a TOP below the count is never seen as a match.
  function automatic logic hits_top(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] t,
                                    input logic ctc);
    return ctc && (c == t);
  endfunction

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic [CNT_W-1:0] t,
                                            input logic ctc);
    return hits_top(c, t, ctc) ? '0 : c + 1'b1;
  endfunction

  logic sw_write;
  assign sw_write  = wr_lo | wr_hi;
  assign match_evt = tick_en && !sw_write && hits_top(cnt_q, top_val, ctc_mode);
  assign wrap_evt  = tick_en && !sw_write && (cnt_q == MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sw_write) begin
      if (wr_lo) cnt_q[HALF-1:0]     <= wr_byte;
      if (wr_hi) cnt_q[CNT_W-1:HALF] <= wr_byte;
    end else if (tick_en) begin
      cnt_q <= step(cnt_q, top_val, ctc_mode);
    end
  end
endmodule

// File: rtl/ctc_capture_unit.sv
module ctc_capture_unit #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       evt_in,
  input  logic             src_sel,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             cap_evt,
  output logic [CNT_W-1:0] cap_val
);
  logic [1:0] evt_sync;
  logic       sel_lvl;
  logic       sel_prev;

  for (genvar g = 0; g < 2; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_STAGES-2:0], evt_in[g]};
    end
    assign evt_sync[g] = chain[SYNC_STAGES-1];
  end

  assign sel_lvl = evt_sync[src_sel];
  assign cap_evt = sel_lvl && !sel_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev <= 1'b0;
      cap_val  <= '0;
    end else begin
      sel_prev <= sel_lvl;
      if (cap_evt) cap_val <= cnt_q;
    end
  end
endmodule

// File: rtl/ctc_flag_bank.sv
module ctc_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ctc_reg_file.sv
module ctc_reg_file
  import ctc_timer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_AW-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [REG_AW-1:0]   rd_addr,
  input  logic [2*BYTE_W-1:0] cnt_q,
  input  logic [2*BYTE_W-1:0] cap_val,
  output logic [BYTE_W-1:0]   rd_data,
  output logic                ctc_mode,
  output logic                cap_sel,
  output logic [2*BYTE_W-1:0] top_val,
  output logic                cnt_wr_lo,
  output logic                cnt_wr_hi
);
  localparam int CNT_W = 2 * BYTE_W;

  assign cnt_wr_lo = wr_en && (wr_addr == REG_CNT_LO);
  assign cnt_wr_hi = wr_en && (wr_addr == REG_CNT_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctc_mode <= 1'b0;
      cap_sel  <= 1'b0;
      top_val  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_CTRL: begin
          ctc_mode <= wr_data[0];
          cap_sel  <= wr_data[1];
        end
        REG_TOP_LO: top_val[BYTE_W-1:0]     <= wr_data;
        REG_TOP_HI: top_val[CNT_W-1:BYTE_W] <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_CTRL:   rd_data = {{(BYTE_W-2){1'b0}}, cap_sel, ctc_mode};
      REG_CNT_LO: rd_data = cnt_q[BYTE_W-1:0];
      REG_CNT_HI: rd_data = cnt_q[CNT_W-1:BYTE_W];
      REG_TOP_LO: rd_data = top_val[BYTE_W-1:0];
      REG_TOP_HI: rd_data = top_val[CNT_W-1:BYTE_W];
      REG_CAP_LO: rd_data = cap_val[BYTE_W-1:0];
      REG_CAP_HI: rd_data = cap_val[CNT_W-1:BYTE_W];
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/capture_ctc_timer.sv
module capture_ctc_timer
  import ctc_timer_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              evt_a,
  input  logic              evt_b,
  input  logic              cmp_clr,
  input  logic              ovf_clr,
  input  logic              cap_clr,
  output logic              cmp_flag,
  output logic              ovf_flag,
  output logic              cap_flag
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     top_val;
  logic [CNT_W-1:0]     cap_val;
  logic                 ctc_mode;
  logic                 cap_sel;
  logic                 cnt_wr_lo;
  logic                 cnt_wr_hi;
  logic                 cnt_wr;
  logic                 match_evt;
  logic                 wrap_evt;
  logic                 cap_evt;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_clr;
  logic [NUM_FLAGS-1:0] flag_q;

  assign cnt_wr = cnt_wr_lo | cnt_wr_hi;

  ctc_reg_file #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .cnt_q(cnt_q), .cap_val(cap_val),
    .rd_data(rd_data), .ctc_mode(ctc_mode), .cap_sel(cap_sel),
    .top_val(top_val), .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi)
  );

  ctc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctc_mode(ctc_mode),
    .top_val(top_val), .wr_lo(cnt_wr_lo), .wr_hi(cnt_wr_hi),
    .wr_byte(wr_data), .cnt_q(cnt_q), .match_evt(match_evt),
    .wrap_evt(wrap_evt)
  );

  ctc_capture_unit #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst_n(rst_n), .evt_in({evt_b, evt_a}), .src_sel(cap_sel),
    .cnt_q(cnt_q), .cap_evt(cap_evt), .cap_val(cap_val)
  );

  always_comb begin
    flag_set           = '0;
    flag_clr           = '0;
    flag_set[FLAG_CMP] = match_evt;
    flag_set[FLAG_OVF] = wrap_evt;
    flag_set[FLAG_CAP] = cap_evt;
    flag_clr[FLAG_CMP] = cmp_clr;
    flag_clr[FLAG_OVF] = ovf_clr;
    flag_clr[FLAG_CAP] = cap_clr;
  end

  ctc_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr),
    .flag_q(flag_q)
  );

  assign cmp_flag = flag_q[FLAG_CMP];
  assign ovf_flag = flag_q[FLAG_OVF];
  assign cap_flag = flag_q[FLAG_CAP];
endmodule

// File: rtl/ctc_timer_chk.sv
module ctc_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_en,
  input logic               ctc_mode,
  input logic [CNT_W-1:0]   top_val,
  input logic [CNT_W-1:0]   cnt_q,
  input logic               cnt_wr,
  input logic               cnt_wr_lo,
  input logic [CNT_W/2-1:0] wr_byte,
  input logic               match_evt,
  input logic               cap_evt,
  input logic [CNT_W-1:0]   cap_val,
  input logic               cmp_clr,
  input logic               cmp_flag,
  input logic               ovf_flag,
  input logic               cap_flag
);
  localparam int HALF = CNT_W / 2;
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !cnt_wr |=> $stable(cnt_q));

  assert_ctc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && ctc_mode && !cnt_wr && (cnt_q == top_val) |=> (cnt_q == '0) && cmp_flag);

  assert_no_early_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !cnt_wr && (cnt_q != MAXV) && !(ctc_mode && (cnt_q == top_val))
    |=> cnt_q == $past(cnt_q) + ONE);

  assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !cnt_wr && (cnt_q == MAXV) |=> (cnt_q == '0) && ovf_flag);

  assert_write_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_lo |=> cnt_q[HALF-1:0] == $past(wr_byte));

  assert_cap_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_val == $past(cnt_q)) && cap_flag);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_flag && !cmp_clr |=> cmp_flag);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> cmp_flag);
endmodule

bind capture_ctc_timer ctc_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctc_mode(ctc_mode),
  .top_val(top_val), .cnt_q(cnt_q), .cnt_wr(cnt_wr), .cnt_wr_lo(cnt_wr_lo),
  .wr_byte(wr_data), .match_evt(match_evt), .cap_evt(cap_evt),
  .cap_val(cap_val), .cmp_clr(cmp_clr), .cmp_flag(cmp_flag),
  .ovf_flag(ovf_flag), .cap_flag(cap_flag)
);

// File: tb/capture_ctc_timer_tb.sv
`timescale 1ns/1ps
module capture_ctc_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       evt_a = 1'b0, evt_b = 1'b0;
  logic       cmp_clr = 1'b0, ovf_clr = 1'b0, cap_clr = 1'b0;
  logic       cmp_flag, ovf_flag, cap_flag;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  capture_ctc_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .evt_a(evt_a), .evt_b(evt_b), .cmp_clr(cmp_clr),
    .ovf_clr(ovf_clr), .cap_clr(cap_clr), .cmp_flag(cmp_flag),
    .ovf_flag(ovf_flag), .cap_flag(cap_flag)
  );

  // Register addresses as laid out in R3
  localparam logic [2:0] A_CTRL = 3'd0, A_CLO = 3'd1, A_CHI = 3'd2,
                         A_TLO = 3'd3, A_THI = 3'd4, A_PLO = 3'd5, A_PHI = 3'd6;

  typedef struct packed {
    logic        ctc;
    logic [15:0] top;
    logic [15:0] start;
    logic [7:0]  ticks;
    logic [15:0] exp_cnt;
    logic        exp_cmp;
    logic        exp_ovf;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0012, 16'h0010, 8'd5, 16'h0015, 1'b0, 1'b0}, // R2 TOP ignored
    '{1'b0, 16'h0000, 16'hFFFE, 8'd3, 16'h0001, 1'b0, 1'b1}, // R6 free-run wrap
    '{1'b1, 16'h0004, 16'h0000, 8'd5, 16'h0000, 1'b1, 1'b0}, // R4 clear at TOP
    '{1'b1, 16'h0004, 16'h0000, 8'd7, 16'h0002, 1'b1, 1'b0}, // R4 restart
    '{1'b1, 16'h0104, 16'h0100, 8'd4, 16'h0104, 1'b0, 1'b0}, // R3 high byte of TOP
    '{1'b1, 16'h0010, 16'h0020, 8'd3, 16'h0023, 1'b0, 1'b0}, // R5 missed match
    '{1'b1, 16'h0002, 16'hFFFE, 8'd5, 16'h0000, 1'b1, 1'b1}, // R5 wrap then match
    '{1'b1, 16'hFFFF, 16'hFFFD, 8'd3, 16'h0000, 1'b1, 1'b1}, // R6 TOP at max
    '{1'b1, 16'h0000, 16'h0000, 8'd3, 16'h0000, 1'b1, 1'b0}  // R4 TOP zero
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
    wr(lo, v[7:0]);
    wr(lo + 3'd1, v[15:8]);
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    rd_addr = lo;      #1; v[7:0]  = rd_data;
    rd_addr = lo + 3'd1; #1; v[15:8] = rd_data;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    cmp_clr = 1'b1; ovf_clr = 1'b1; cap_clr = 1'b1;
    @(negedge clk);
    cmp_clr = 1'b0; ovf_clr = 1'b0; cap_clr = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_addr = A_CTRL; #1;
    check("R1 ctrl", rd_data, 8'h00);
    rd16(A_CLO, v); check("R1 count", v, 16'h0);
    rd16(A_TLO, v); check("R1 top", v, 16'h0);
    rd16(A_PLO, v); check("R1 capture", v, 16'h0);
    check("R1 flags", {cmp_flag, ovf_flag, cap_flag}, 3'b000);
    rd_addr = 3'd7; #1;
    check("R3 unused address", rd_data, 8'h00);

    // Table walk: R2 R3 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      wr(A_CTRL, {7'b0, VECS[k].ctc});
      wr16(A_TLO, VECS[k].top);
      wr16(A_CLO, VECS[k].start);
      clear_flags();
      run_ticks(int'(VECS[k].ticks));
      rd16(A_CLO, v);
      check($sformatf("vector %0d count (R2/R4/R5/R6)", k), v, VECS[k].exp_cnt);
      check($sformatf("vector %0d cmp_flag (R4/R5)", k), cmp_flag, VECS[k].exp_cmp);
      check($sformatf("vector %0d ovf_flag (R6)", k), ovf_flag, VECS[k].exp_ovf);
    end
    rd16(A_TLO, v); check("R3 top readback", v, 16'h0000);

    // R7: counter write collides with a tick that would match
    wr(A_CTRL, 8'h01);
    wr16(A_TLO, 16'h0005);
    wr16(A_CLO, 16'h0005);
    clear_flags();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_CLO; wr_data = 8'h33; tick_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    rd16(A_CLO, v);
    check("R7 write beats tick", v, 16'h0033);
    check("R7 no flag from dropped tick", cmp_flag, 1'b0);

    // R9: set and clear on the same edge, then sticky, then clear
    wr16(A_TLO, 16'h0000);
    wr16(A_CLO, 16'h0000);
    clear_flags();
    @(negedge clk);
    tick_en = 1'b1; cmp_clr = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; cmp_clr = 1'b0;
    check("R9 set wins", cmp_flag, 1'b1);
    repeat (3) @(negedge clk);
    check("R9 sticky", cmp_flag, 1'b1);
    @(negedge clk); cmp_clr = 1'b1;
    @(negedge clk); cmp_clr = 1'b0;
    check("R9 cleared", cmp_flag, 1'b0);

    // R2: no tick holds the count
    wr16(A_CLO, 16'h1234);
    repeat (5) @(negedge clk);
    rd16(A_CLO, v);
    check("R2 hold without tick", v, 16'h1234);

    // R8: capture from input A
    wr(A_CTRL, 8'h00);
    clear_flags();
    evt_a = 1'b1;
    repeat (4) @(negedge clk);
    rd16(A_PLO, v);
    check("R8 capture A value", v, 16'h1234);
    check("R8 capture A flag", cap_flag, 1'b1);

    // R8: unselected input B ignored
    evt_a = 1'b0;
    clear_flags();
    wr16(A_CLO, 16'h2222);
    evt_b = 1'b1;
    repeat (4) @(negedge clk);
    rd16(A_PLO, v);
    check("R8 unselected input value", v, 16'h1234);
    check("R8 unselected input flag", cap_flag, 1'b0);

    // R8: capture from input B once selected
    evt_b = 1'b0;
    repeat (4) @(negedge clk);
    wr(A_CTRL, 8'h02);
    clear_flags();
    wr16(A_CLO, 16'h3456);
    evt_b = 1'b1;
    repeat (4) @(negedge clk);
    rd16(A_PLO, v);
    check("R8 capture B value", v, 16'h3456);
    check("R8 capture B flag", cap_flag, 1'b1);
    rd_addr = A_CTRL; #1;
    check("R3 ctrl readback", rd_data, 8'h02);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule